// File: doc/BRIEF.md
# Write-Triggered Descriptor Queue

This block gathers the fields of a transfer descriptor through ordinary 32-bit register writes and places each complete descriptor into an internal FIFO. A downstream transfer engine takes the descriptors through a valid/ready port. Three writable registers hold the fields: the configuration base address, the configuration length, and the input/output base address. The configuration length is the number of 64-bit configuration words minus two, and it is passed through unchanged. Only a write to the input/output base register creates a descriptor. The other two fields keep their values, so software can issue a series of requests that share one configuration by writing the input/output base alone.

A read-only diagnostics word has three flags. The first is a sticky flag that records an enqueue lost to a full FIFO. The second reports that the FIFO is full or nearly full. The third reports that an optional cap on accepted requests has been reached. Once the cap is reached, every later enqueue is refused.

Top module: `desc_queue`

## Requirements
- R1: After reset, `desc_valid` is 0. Reads of offsets 0x0, 0x4, 0x8 and 0xC all return 0.
- R2: A write to offset 0x0 or 0x4, or to any undecoded offset, stores its value if the offset is decoded. It never adds a descriptor.
- R3: A write to offset 0x8 adds one descriptor. The descriptor is {configuration base held at 0x0, length held at 0x4, aligned write data}. The length field is the written value exactly (64-bit words minus 2).
- R4: The values at 0x0 and 0x4 persist across enqueues. Back-to-back writes to 0x8 give descriptors that share the last-written base and length.
- R5: A read strobe returns its data in `reg_rdata` one cycle later. Offsets 0x0 and 0x8 return the last written value with bits [2:0] cleared. Offset 0x4 returns the written value. Undecoded offsets return 0.
- R6: Descriptors leave in write order. `desc_valid` is high exactly while the FIFO holds entries. An offered descriptor holds steady until `desc_ready` takes it.
- R7: An enqueue that arrives while the FIFO holds DEPTH entries is dropped. The stored descriptors and their order are left intact.
- R8: Diagnostics bit 0 goes to 1 on a dropped enqueue. Only reset clears it.
- R9: Diagnostics bit 1 equals (occupancy >= DEPTH - AFULL_GAP).
- R10: With REQ_LIMIT > 0, diagnostics bit 2 is set once REQ_LIMIT enqueues have been accepted. From then on, each enqueue is refused without touching bit 0. With REQ_LIMIT = 0, bit 2 stays 0.
- R11: Diagnostics bits [31:3] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| desc_valid | output | 1 | A descriptor is offered |
| desc_ready | input | 1 | Consumer takes the offered descriptor |
| desc_cfg_base | output | 32 | Configuration/filter base address of the descriptor |
| desc_cfg_len | output | 32 | Configuration length field (words minus 2) |
| desc_io_base | output | 32 | Input/output base address of the descriptor |

## Verification
The bench steps through several configuration values whose low address bits are deliberately misaligned. This separates correct masking and storage from pass-through, and confirms that configuration writes alone never enqueue.

A run of input/output writes fills the FIFO one entry at a time, with the configuration changed partway through. This separates field reuse from field capture at write time, and it checks the near-full flag at every occupancy from 0 to DEPTH. One extra write past full tells a dropped enqueue from an overwrite, because the drain order and contents are then compared.

A second instance with a small request cap separates a cap refusal from a full-FIFO drop.

// File: rtl/desc_queue_pkg.sv
package desc_queue_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int ALIGN_BITS = 3;   // 64-bit memory word

    localparam logic [ADDR_W-1:0] OFS_CFG_BASE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG_LEN  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_IO_BASE  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_DIAG     = 4'hC;

    localparam int DIAG_W = 3;

    typedef struct packed {
        logic [DATA_W-1:0] cfg_base;
        logic [DATA_W-1:0] cfg_len;
        logic [DATA_W-1:0] io_base;
    } desc_t;

    // bit 0 = ovf, bit 1 = afull, bit 2 = limit
    typedef struct packed {
        logic limit;
        logic afull;
        logic ovf;
    } diag_t;

    typedef enum logic [1:0] {
        ENQ_NONE,
        ENQ_PUSH,
        ENQ_DROP_FULL,
        ENQ_DROP_LIMIT
    } enq_res_t;

    function automatic logic [DATA_W-1:0] align_addr(input logic [DATA_W-1:0] a);
        return {a[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/desc_regfile.sv
module desc_regfile
    import desc_queue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    input  diag_t             diag,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              enq_req,
    output desc_t             enq_desc
);

    logic [DATA_W-1:0] cfg_base_q;
    logic [DATA_W-1:0] cfg_len_q;
    logic [DATA_W-1:0] io_base_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_base_q <= '0;
            cfg_len_q  <= '0;
            io_base_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CFG_BASE: cfg_base_q <= align_addr(reg_wdata);
                OFS_CFG_LEN:  cfg_len_q  <= reg_wdata;
                OFS_IO_BASE:  io_base_q  <= align_addr(reg_wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                OFS_CFG_BASE: rdata_q <= cfg_base_q;
                OFS_CFG_LEN:  rdata_q <= cfg_len_q;
                OFS_IO_BASE:  rdata_q <= io_base_q;
                OFS_DIAG:     rdata_q <= {{(DATA_W-DIAG_W){1'b0}}, diag};
                default:      rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;

    // The enqueue is the write itself; the held fields are combined with the new address.
    always_comb begin
        enq_req           = reg_wr && (reg_addr == OFS_IO_BASE);
        enq_desc.cfg_base = cfg_base_q;
        enq_desc.cfg_len  = cfg_len_q;
        enq_desc.io_base  = align_addr(reg_wdata);
    end

    // R4: held fields do not move when the trigger register is written
    p_fields_held_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_IO_BASE) |=> ($stable(cfg_base_q) && $stable(cfg_len_q)));

endmodule

// File: rtl/desc_enq_gate.sv
module desc_enq_gate
    import desc_queue_pkg::*;
#(
    parameter int REQ_LIMIT = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic enq_req,
    input  logic fifo_full,
    output logic push,
    output logic ovf,
    output logic limit_hit
);

    enq_res_t res;
    logic     ovf_q;

    always_comb begin
        if (!enq_req)       res = ENQ_NONE;
        else if (limit_hit) res = ENQ_DROP_LIMIT;
        else if (fifo_full) res = ENQ_DROP_FULL;
        else                res = ENQ_PUSH;
    end

    assign push = (res == ENQ_PUSH);

    always_ff @(posedge clk) begin
        if (rst)                       ovf_q <= 1'b0;
        else if (res == ENQ_DROP_FULL) ovf_q <= 1'b1;
    end

    assign ovf = ovf_q;

    generate
        if (REQ_LIMIT == 0) begin : g_unlimited
            assign limit_hit = 1'b0;
        end else begin : g_limited
            localparam int CW = $clog2(REQ_LIMIT + 1);
            logic [CW-1:0] acc_q;

            always_ff @(posedge clk) begin
                if (rst)                    acc_q <= '0;
                else if (push && !limit_hit) acc_q <= acc_q + CW'(1);
            end

            assign limit_hit = (acc_q == CW'(REQ_LIMIT));

            // R10: once reached, the cap stays reached until reset
            p_limit_sticky_r10: assert property (@(posedge clk) disable iff (rst)
                limit_hit |=> limit_hit);
        end
    endgenerate

    // R8: overflow flag never falls without reset
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R10: a refused request leaves the overflow flag as it was
    p_limit_no_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        (enq_req && limit_hit) |=> $stable(ovf_q));

endmodule

// File: rtl/desc_fifo.sv
module desc_fifo
    import desc_queue_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int AFULL_GAP = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  desc_t push_data,
    output logic  out_valid,
    input  logic  out_ready,
    output desc_t out_data,
    output logic  full,
    output logic  afull,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AFULL_LVL = (DEPTH > AFULL_GAP) ? (DEPTH - AFULL_GAP) : 0;

    desc_t             mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (count_q == CNT_W'(DEPTH));
    assign afull     = (count_q >= CNT_W'(AFULL_LVL));
    assign out_valid = (count_q != '0);
    assign pop       = out_valid && out_ready;
    assign out_data  = mem[rd_ptr_q];
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push && !full) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)           rd_ptr_q <= ptr_next(rd_ptr_q);
            case ({push && !full, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: ;
            endcase
        end
    end

    // R6: an offered descriptor waits unchanged for the consumer
    p_hold_until_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: a full FIFO always reports near-full
    p_full_implies_afull_r9: assert property (@(posedge clk) disable iff (rst)
        full |-> afull);

endmodule

// File: rtl/desc_queue.sv
module desc_queue
    import desc_queue_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int AFULL_GAP = 2,
    parameter int REQ_LIMIT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    output logic        desc_valid,
    input  logic        desc_ready,
    output logic [31:0] desc_cfg_base,
    output logic [31:0] desc_cfg_len,
    output logic [31:0] desc_io_base
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             enq_req, push, fifo_full, fifo_afull;
    logic             ovf, limit_hit;
    desc_t            enq_desc, head;
    diag_t            diag;
    logic [CNT_W-1:0] fifo_count;

    assign diag = '{limit: limit_hit, afull: fifo_afull, ovf: ovf};

    desc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .diag      (diag),
        .reg_rdata (reg_rdata),
        .enq_req   (enq_req),
        .enq_desc  (enq_desc)
    );

    desc_enq_gate #(.REQ_LIMIT(REQ_LIMIT)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .enq_req   (enq_req),
        .fifo_full (fifo_full),
        .push      (push),
        .ovf       (ovf),
        .limit_hit (limit_hit)
    );

    desc_fifo #(.DEPTH(DEPTH), .AFULL_GAP(AFULL_GAP)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (enq_desc),
        .out_valid (desc_valid),
        .out_ready (desc_ready),
        .out_data  (head),
        .full      (fifo_full),
        .afull     (fifo_afull),
        .count     (fifo_count)
    );

    assign desc_cfg_base = head.cfg_base;
    assign desc_cfg_len  = head.cfg_len;
    assign desc_io_base  = head.io_base;

    // R2: writes elsewhere than the trigger offset never add an entry
    p_cfg_write_no_push_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != OFS_IO_BASE && !(desc_valid && desc_ready))
        |=> $stable(fifo_count));

    // R7: a write against a full FIFO with no drain leaves occupancy alone
    p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_IO_BASE && fifo_full && !desc_ready)
        |=> (fifo_full && $stable(fifo_count)));

    // R8: a dropped write raises the overflow flag
    p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        (enq_req && fifo_full && !limit_hit) |=> ovf);

endmodule

// File: tb/desc_queue_tb.sv
`timescale 1ns/1ps
module desc_queue_tb;

    localparam int DEPTH = 4;
    localparam int GAP   = 1;
    localparam int LIM   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // main instance (no request cap)
    logic [3:0]  m_addr = '0;
    logic        m_wr = 1'b0, m_rd = 1'b0, m_ready = 1'b0;
    logic [31:0] m_wdata = '0, m_rdata, m_cb, m_cl, m_io;
    logic        m_valid;

    // capped instance
    logic [3:0]  l_addr = '0;
    logic        l_wr = 1'b0, l_rd = 1'b0, l_ready = 1'b0;
    logic [31:0] l_wdata = '0, l_rdata, l_cb, l_cl, l_io;
    logic        l_valid;

    desc_queue #(.DEPTH(DEPTH), .AFULL_GAP(GAP), .REQ_LIMIT(0)) u_dut (
        .clk(clk), .rst(rst), .reg_addr(m_addr), .reg_wr(m_wr), .reg_wdata(m_wdata),
        .reg_rd(m_rd), .reg_rdata(m_rdata), .desc_valid(m_valid), .desc_ready(m_ready),
        .desc_cfg_base(m_cb), .desc_cfg_len(m_cl), .desc_io_base(m_io));

    desc_queue #(.DEPTH(DEPTH), .AFULL_GAP(GAP), .REQ_LIMIT(LIM)) u_dut_lim (
        .clk(clk), .rst(rst), .reg_addr(l_addr), .reg_wr(l_wr), .reg_wdata(l_wdata),
        .reg_rd(l_rd), .reg_rdata(l_rdata), .desc_valid(l_valid), .desc_ready(l_ready),
        .desc_cfg_base(l_cb), .desc_cfg_len(l_cl), .desc_io_base(l_io));

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] q_cb[$], q_cl[$], q_io[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic wr(input bit lim, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (lim) begin l_wr = 1'b1; l_addr = a; l_wdata = d; end
        else     begin m_wr = 1'b1; m_addr = a; m_wdata = d; end
        @(negedge clk);
        l_wr = 1'b0; m_wr = 1'b0;
    endtask

    task automatic rd(input bit lim, input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        if (lim) begin l_rd = 1'b1; l_addr = a; end
        else     begin m_rd = 1'b1; m_addr = a; end
        @(negedge clk);
        l_rd = 1'b0; m_rd = 1'b0;
        d = lim ? l_rdata : m_rdata;
    endtask

    task automatic rd_chk(input bit lim, input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(lim, a, d);
        check(req, d, exp);
    endtask

    // take one descriptor from the main instance and compare with the model
    task automatic pop_chk(input string req);
        check({req, " valid"}, {31'b0, m_valid}, 32'd1);
        check({req, " cfg_base"}, m_cb, q_cb.pop_front());
        check({req, " cfg_len"},  m_cl, q_cl.pop_front());
        check({req, " io_base"},  m_io, q_io.pop_front());
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] base, len, io, hold_cb, hold_io;
        int occ;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 valid after reset", {31'b0, m_valid}, 32'd0);
        rd_chk(0, 4'h0, 32'h0, "R1 cfg_base");
        rd_chk(0, 4'h4, 32'h0, "R1 cfg_len");
        rd_chk(0, 4'h8, 32'h0, "R1 io_base");
        rd_chk(0, 4'hC, 32'h0, "R1 diag");

        // R2/R5: configuration sweep with misaligned bases
        for (int i = 0; i < 8; i++) begin
            base = 32'h1000_0000 + i * 32'h111;
            len  = 32'd5 + i;
            wr(0, 4'h0, base);
            wr(0, 4'h4, len);
            rd_chk(0, 4'h0, base & ~32'h7, "R5 cfg_base aligned");
            rd_chk(0, 4'h4, len, "R5 cfg_len as written");
            check("R2 no push from cfg writes", {31'b0, m_valid}, 32'd0);
        end
        wr(0, 4'h2, 32'hFFFF_FFFF);
        check("R2 undecoded write no push", {31'b0, m_valid}, 32'd0);
        rd_chk(0, 4'h2, 32'h0, "R5 undecoded read");

        // R3/R4/R9/R7/R8: fill to full, change configuration before the 4th entry
        for (int k = 0; k < DEPTH + 1; k++) begin
            if (k == 3) begin
                base = 32'h3000_0042;
                len  = 32'd30;
                wr(0, 4'h0, base);
                wr(0, 4'h4, len);
            end
            io = 32'h2000_0000 + k * 32'h48 + k;
            wr(0, 4'h8, io);
            if (k < DEPTH) begin
                q_cb.push_back(base & ~32'h7);
                q_cl.push_back(len);
                q_io.push_back(io & ~32'h7);
            end
            occ = (k + 1 < DEPTH) ? k + 1 : DEPTH;
            check("R6 valid when non-empty", {31'b0, m_valid}, 32'd1);
            rd_chk(0, 4'hC, {29'b0, 1'b0, (occ >= DEPTH - GAP), (k == DEPTH)},
                   "R9 R8 R10 R11 diag during fill");
            rd_chk(0, 4'h8, io & ~32'h7, "R5 io_base readback");
        end

        // R6: hold while not ready
        hold_cb = m_cb; hold_io = m_io;
        repeat (3) begin
            @(negedge clk);
            check("R6 hold cfg_base", m_cb, hold_cb);
            check("R6 hold io_base", m_io, hold_io);
        end

        // R3/R4/R6/R7: drain and compare order and contents
        for (int k = 0; k < DEPTH; k++) pop_chk("R3 R4 R7 drain");
        check("R6 empty after drain", {31'b0, m_valid}, 32'd0);
        rd_chk(0, 4'hC, 32'h1, "R8 ovf sticky after drain");

        // R1/R8: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk(0, 4'hC, 32'h0, "R8 ovf cleared by reset");
        rd_chk(0, 4'h0, 32'h0, "R1 cfg_base after reset");
        rd_chk(0, 4'h8, 32'h0, "R1 io_base after reset");

        // R10: capped instance
        wr(1, 4'h0, 32'h4000_0000);
        wr(1, 4'h4, 32'd7);
        for (int k = 0; k < LIM + 2; k++) begin
            io = 32'h5000_0000 + k * 32'h100;
            wr(1, 4'h8, io);
            if (k < LIM) begin
                check("R10 accepted below cap", {31'b0, l_valid}, 32'd1);
                check("R3 capped io_base", l_io, io);
                check("R4 capped cfg_len", l_cl, 32'd7);
                l_ready = 1'b1;
                @(negedge clk);
                l_ready = 1'b0;
            end else begin
                check("R10 refused at cap", {31'b0, l_valid}, 32'd0);
            end
            rd_chk(1, 4'hC, {29'b0, (k >= LIM - 1), 1'b0, 1'b0}, "R10 limit flag, no ovf");
        end

        finish_run();
    end

endmodule